// File: doc/BRIEF.md
# Exception Entry Stack Frame Sequencer

This block writes the stack frame that a processor core leaves in memory when it takes a page fault. It is given the privilege state of the interrupted code: the code selector, the stack selector, the stack pointer, the flags word and the address of the faulting instruction. It is also given the fault error code, the kernel stack selector and pointer, and the entry point of the fault handler. When started, it sends the frame to memory one 32-bit word per cycle through a simple write port that the memory can stall.

The privilege level is the low two bits of the code selector. At level 0 the frame goes onto the current stack and holds four words. At any other level the block first moves to the kernel stack. The frame then holds six words, because the old stack selector and stack pointer are saved ahead of the rest.

When the last word is accepted, the block pulses `done_o` and presents the new stack selector and pointer, and the handler's code selector and entry address. The stack pointer it presents points at the error code.

Top module: `exc_frame_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_we_o`, `busy_o` and `done_o` are low.
- R2: When `cs_sel_i[1:0]` is 0, the frame is written on stack selector `ss_sel_i`. It has four words: EFLAGS at `esp_i`-4, CS zero-extended at `esp_i`-8, EIP at `esp_i`-12, and the error code at `esp_i`-16, written in that order.
- R3: When `cs_sel_i[1:0]` is 1, 2 or 3, the frame is written on stack selector `kss_sel_i`. It has six words: old SS zero-extended at `kesp_i`-4, old ESP at -8, EFLAGS at -12, CS at -16, EIP at -20, and the error code at -24, written in that order.
- R4: The first write is offered in the cycle after `start_i` is sampled while idle. Each later write is offered in the cycle after the previous one is accepted (`mem_we_o` and `mem_rdy_i` both high). The address of each write is 4 below the address of the write before it.
- R5: While `mem_we_o` is high and `mem_rdy_i` is low, `mem_addr_o`, `mem_wdata_o` and `mem_seg_o` hold their values.
- R6: `done_o` is high for exactly one cycle, the cycle after the final write is accepted. In that cycle `new_ss_o` and `new_esp_o` equal the selector and address of the error-code word, and `new_cs_o` and `new_eip_o` equal the handler inputs. These outputs hold until the next `done_o`.
- R7: The saved EIP word equals `eip_i` exactly (the faulting instruction, not advanced).
- R8: `start_i` while `busy_o` is high is ignored; the frame in progress is unchanged.
- R9: All inputs are captured when the start is accepted; later changes to them do not alter the frame or the handoff values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to build a frame |
| cs_sel_i | input | SEL_W | Code selector of the interrupted code; bits 1:0 are its privilege level |
| ss_sel_i | input | SEL_W | Current stack selector |
| esp_i | input | DATA_W | Current stack pointer |
| eflags_i | input | DATA_W | Flags word to save |
| eip_i | input | DATA_W | Address of the faulting instruction |
| err_code_i | input | DATA_W | Fault error code |
| kss_sel_i | input | SEL_W | Kernel stack selector |
| kesp_i | input | DATA_W | Kernel stack pointer |
| hnd_cs_i | input | SEL_W | Handler code selector |
| hnd_eip_i | input | DATA_W | Handler entry address |
| mem_rdy_i | input | 1 | Memory accepts the offered write |
| mem_we_o | output | 1 | Write offered |
| mem_seg_o | output | SEL_W | Stack selector of the write |
| mem_addr_o | output | DATA_W | Stack offset of the write |
| mem_wdata_o | output | DATA_W | Word written |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_ss_o | output | SEL_W | Stack selector after entry |
| new_esp_o | output | DATA_W | Stack pointer after entry |
| new_cs_o | output | SEL_W | Code selector of the handler |
| new_eip_o | output | DATA_W | Entry address of the handler |

## Verification
A wrong word index or a wrong mode decision shows at the write port on the very next accepted write, as a word in the wrong slot or a frame that is too short or too long. A wrong address register shows in the same cycle as an address that does not step by four. Errors in the handoff registers show in the `done_o` cycle. A start that should have been ignored shows within one cycle, because the next offered word or address no longer follows the frame in progress.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  localparam int MAX_WORDS    = 6;
  localparam int KERNEL_WORDS = 6;
  localparam int SAME_WORDS   = 4;
  localparam int IDX_W        = $clog2(MAX_WORDS);

  typedef enum logic {ST_IDLE, ST_PUSH} seq_state_t;
endpackage

// File: rtl/exc_frame_build.sv
module exc_frame_build
  import exc_frame_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic [SEL_W-1:0]                  cs_sel_i,
  input  logic [SEL_W-1:0]                  ss_sel_i,
  input  logic [DATA_W-1:0]                 esp_i,
  input  logic [DATA_W-1:0]                 eflags_i,
  input  logic [DATA_W-1:0]                 eip_i,
  input  logic [DATA_W-1:0]                 err_code_i,
  input  logic [SEL_W-1:0]                  kss_sel_i,
  input  logic [DATA_W-1:0]                 kesp_i,
  output logic [MAX_WORDS-1:0][DATA_W-1:0]  words_o,
  output logic [IDX_W-1:0]                  last_idx_o,
  output logic [SEL_W-1:0]                  stk_sel_o,
  output logic [DATA_W-1:0]                 stk_top_o
);
  localparam int PAD_W = DATA_W - SEL_W;
  localparam int SKIP  = KERNEL_WORDS - SAME_WORDS;

  logic                             to_kernel;
  logic [MAX_WORDS-1:0][DATA_W-1:0] full;

  // privilege level from the selector's low two bits; any nonzero level switches
  assign to_kernel = (cs_sel_i[1:0] != 2'd0);

  assign full[0] = {{PAD_W{1'b0}}, ss_sel_i};
  assign full[1] = esp_i;
  assign full[2] = eflags_i;
  assign full[3] = {{PAD_W{1'b0}}, cs_sel_i};
  assign full[4] = eip_i;
  assign full[5] = err_code_i;

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
    if (i + SKIP < MAX_WORDS) begin : g_shift
      assign words_o[i] = to_kernel ? full[i] : full[i+SKIP];
    end else begin : g_tail
      assign words_o[i] = to_kernel ? full[i] : '0;
    end
  end

  assign last_idx_o = to_kernel ? IDX_W'(KERNEL_WORDS - 1) : IDX_W'(SAME_WORDS - 1);
  assign stk_sel_o  = to_kernel ? kss_sel_i : ss_sel_i;
  assign stk_top_o  = to_kernel ? kesp_i : esp_i;
endmodule

// File: rtl/exc_push_seq.sv
module exc_push_seq
  import exc_frame_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic [MAX_WORDS-1:0][DATA_W-1:0]  words_i,
  input  logic [IDX_W-1:0]                  last_idx_i,
  input  logic [SEL_W-1:0]                  stk_sel_i,
  input  logic [DATA_W-1:0]                 stk_top_i,
  input  logic [SEL_W-1:0]                  hnd_cs_i,
  input  logic [DATA_W-1:0]                 hnd_eip_i,
  input  logic                              mem_rdy_i,
  output logic                              mem_we_o,
  output logic [SEL_W-1:0]                  mem_seg_o,
  output logic [DATA_W-1:0]                 mem_addr_o,
  output logic [DATA_W-1:0]                 mem_wdata_o,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [SEL_W-1:0]                  new_ss_o,
  output logic [DATA_W-1:0]                 new_esp_o,
  output logic [SEL_W-1:0]                  new_cs_o,
  output logic [DATA_W-1:0]                 new_eip_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  seq_state_t                       state_q;
  logic [MAX_WORDS-1:0][DATA_W-1:0] words_q;
  logic [IDX_W-1:0]                 last_q;
  logic [IDX_W-1:0]                 idx_q;
  logic [IDX_W-1:0]                 idx_nx;
  logic [SEL_W-1:0]                 hcs_q;
  logic [DATA_W-1:0]                heip_q;

  assign idx_nx = idx_q + IDX_W'(1);
  assign busy_o = (state_q == ST_PUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      words_q     <= '0;
      last_q      <= '0;
      idx_q       <= '0;
      hcs_q       <= '0;
      heip_q      <= '0;
      mem_we_o    <= 1'b0;
      mem_seg_o   <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      new_ss_o    <= '0;
      new_esp_o   <= '0;
      new_cs_o    <= '0;
      new_eip_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_PUSH;
            words_q     <= words_i;
            last_q      <= last_idx_i;
            idx_q       <= '0;
            hcs_q       <= hnd_cs_i;
            heip_q      <= hnd_eip_i;
            mem_we_o    <= 1'b1;
            mem_seg_o   <= stk_sel_i;
            mem_addr_o  <= stk_top_i - STEP;
            mem_wdata_o <= words_i[0];
          end
        end
        ST_PUSH: begin
          if (mem_rdy_i) begin
            if (idx_q == last_q) begin
              state_q   <= ST_IDLE;
              mem_we_o  <= 1'b0;
              done_o    <= 1'b1;
              new_ss_o  <= mem_seg_o;
              new_esp_o <= mem_addr_o;
              new_cs_o  <= hcs_q;
              new_eip_o <= heip_q;
            end else begin
              idx_q       <= idx_nx;
              mem_addr_o  <= mem_addr_o - STEP;
              mem_wdata_o <= words_q[idx_nx];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  cs_sel_i,
  input  logic [SEL_W-1:0]  ss_sel_i,
  input  logic [DATA_W-1:0] esp_i,
  input  logic [DATA_W-1:0] eflags_i,
  input  logic [DATA_W-1:0] eip_i,
  input  logic [DATA_W-1:0] err_code_i,
  input  logic [SEL_W-1:0]  kss_sel_i,
  input  logic [DATA_W-1:0] kesp_i,
  input  logic [SEL_W-1:0]  hnd_cs_i,
  input  logic [DATA_W-1:0] hnd_eip_i,
  input  logic              mem_rdy_i,
  output logic              mem_we_o,
  output logic [SEL_W-1:0]  mem_seg_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  new_ss_o,
  output logic [DATA_W-1:0] new_esp_o,
  output logic [SEL_W-1:0]  new_cs_o,
  output logic [DATA_W-1:0] new_eip_o
);
  logic [MAX_WORDS-1:0][DATA_W-1:0] words;
  logic [IDX_W-1:0]                 last_idx;
  logic [SEL_W-1:0]                 stk_sel;
  logic [DATA_W-1:0]                stk_top;

  exc_frame_build #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_build (
    .cs_sel_i   (cs_sel_i),
    .ss_sel_i   (ss_sel_i),
    .esp_i      (esp_i),
    .eflags_i   (eflags_i),
    .eip_i      (eip_i),
    .err_code_i (err_code_i),
    .kss_sel_i  (kss_sel_i),
    .kesp_i     (kesp_i),
    .words_o    (words),
    .last_idx_o (last_idx),
    .stk_sel_o  (stk_sel),
    .stk_top_o  (stk_top)
  );

  exc_push_seq #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .words_i     (words),
    .last_idx_i  (last_idx),
    .stk_sel_i   (stk_sel),
    .stk_top_i   (stk_top),
    .hnd_cs_i    (hnd_cs_i),
    .hnd_eip_i   (hnd_eip_i),
    .mem_rdy_i   (mem_rdy_i),
    .mem_we_o    (mem_we_o),
    .mem_seg_o   (mem_seg_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .new_ss_o    (new_ss_o),
    .new_esp_o   (new_esp_o),
    .new_cs_o    (new_cs_o),
    .new_eip_o   (new_eip_o)
  );
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              mem_rdy_i,
  input logic              mem_we_o,
  input logic [SEL_W-1:0]  mem_seg_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [SEL_W-1:0]  new_ss_o,
  input logic [DATA_W-1:0] new_esp_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && mem_rdy_i) |=> (!mem_we_o || mem_addr_o == $past(mem_addr_o) - STEP));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && !mem_rdy_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_seg_o)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_top_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(mem_we_o && mem_rdy_i) && new_esp_o == $past(mem_addr_o) && new_ss_o == $past(mem_seg_o)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !(mem_we_o && mem_rdy_i)) |=> ($stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R1
  we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_exc_frame_seq.sv
`timescale 1ns/1ps
module test_exc_frame_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] cs_sel_i = '0, ss_sel_i = '0, kss_sel_i = '0, hnd_cs_i = '0;
  logic [31:0] esp_i = '0, eflags_i = '0, eip_i = '0, err_code_i = '0, kesp_i = '0, hnd_eip_i = '0;
  logic        mem_rdy_i = 1'b1;
  logic        mem_we_o, busy_o, done_o;
  logic [15:0] mem_seg_o, new_ss_o, new_cs_o;
  logic [31:0] mem_addr_o, mem_wdata_o, new_esp_o, new_eip_o;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int cyc = 0;

  logic [15:0] q_seg[$];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  string       q_req[$];

  always #10 clk = ~clk;

  exc_frame_seq i_exc_frame_seq (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern, changed just after each edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (rdy_mode == 0) mem_rdy_i = 1'b1;
    else               mem_rdy_i = (cyc % 3) != 0;
  end

  // monitor: pops expected writes, checks stalls
  bit          prev_stall = 0;
  logic [31:0] prev_addr, prev_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        // R5
        check(mem_addr_o == prev_addr && mem_wdata_o == prev_data, "R5",
              {mem_addr_o, mem_wdata_o}, {prev_addr, prev_data});
      end
      prev_stall = mem_we_o && !mem_rdy_i;
      prev_addr  = mem_addr_o;
      prev_data  = mem_wdata_o;
      if (mem_we_o && mem_rdy_i) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R2/R3 extra write", {32'd0, mem_addr_o}, 64'd0);
        end else begin
          automatic logic [15:0] es = q_seg.pop_front();
          automatic logic [31:0] ea = q_addr.pop_front();
          automatic logic [31:0] ed = q_data.pop_front();
          automatic string       er = q_req.pop_front();
          check(mem_seg_o == es && mem_addr_o == ea && mem_wdata_o == ed, er,
                {mem_seg_o, mem_addr_o[15:0], mem_wdata_o}, {es, ea[15:0], ed});
        end
      end
    end
  end

  task automatic push_exp(input logic [15:0] s, input logic [31:0] a, input logic [31:0] d, input string r);
    q_seg.push_back(s); q_addr.push_back(a); q_data.push_back(d); q_req.push_back(r);
  endtask

  task automatic fault(input logic [15:0] cs, input logic [15:0] ss, input logic [31:0] esp,
                       input logic [31:0] efl, input logic [31:0] eip, input logic [31:0] err,
                       input logic [15:0] kss, input logic [31:0] kesp,
                       input logic [15:0] hcs, input logic [31:0] heip, input bit poke);
    logic [15:0] seg;
    logic [31:0] a;
    string       rq;
    int          wait_n;
    if (cs[1:0] == 2'd0) begin
      seg = ss; a = esp; rq = "R2";
    end else begin
      seg = kss; a = kesp; rq = "R3";
      a -= 4; push_exp(seg, a, {16'd0, ss}, "R3 old SS");
      a -= 4; push_exp(seg, a, esp, "R3 old ESP");
    end
    a -= 4; push_exp(seg, a, efl, {rq, " EFLAGS"});
    a -= 4; push_exp(seg, a, {16'd0, cs}, {rq, " CS"});
    a -= 4; push_exp(seg, a, eip, "R7 EIP");
    a -= 4; push_exp(seg, a, err, {rq, " error code"});

    @(negedge clk);
    cs_sel_i = cs; ss_sel_i = ss; esp_i = esp; eflags_i = efl; eip_i = eip;
    err_code_i = err; kss_sel_i = kss; kesp_i = kesp; hnd_cs_i = hcs; hnd_eip_i = heip;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R4: first write offered the cycle after start
    check(mem_we_o == 1'b1 && busy_o == 1'b1, "R4", {63'd0, mem_we_o}, 64'd1);
    // R9: scramble inputs after capture
    cs_sel_i = ~cs; ss_sel_i = ~ss; esp_i = ~esp; eflags_i = ~efl; eip_i = ~eip;
    err_code_i = ~err; kss_sel_i = ~kss; kesp_i = ~kesp; hnd_cs_i = ~hcs; hnd_eip_i = ~heip;
    if (poke) begin
      // R8: start while busy
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_n = 0;
    while (!done_o && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    // R6
    check(done_o == 1'b1, "R6 done", {63'd0, done_o}, 64'd1);
    check(new_ss_o == seg && new_esp_o == a, "R6 new stack", {new_ss_o, new_esp_o}, {seg, a});
    check(new_cs_o == hcs && new_eip_o == heip, "R6 R9 handler", {new_cs_o, new_eip_o}, {hcs, heip});
    check(q_addr.size() == 0, "R2/R3 frame length", 64'(q_addr.size()), 64'd0);
    q_seg.delete(); q_addr.delete(); q_data.delete(); q_req.delete();
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R6 pulse width", {62'd0, done_o, busy_o}, 64'd0);
    check(new_cs_o == hcs && new_eip_o == heip && new_esp_o == a, "R6 hold",
          {new_cs_o, new_eip_o}, {hcs, heip});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(mem_we_o == 0 && busy_o == 0 && done_o == 0, "R1 in reset", {61'd0, mem_we_o, busy_o, done_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(mem_we_o == 0 && busy_o == 0 && done_o == 0, "R1 after reset", {61'd0, mem_we_o, busy_o, done_o}, 64'd0);

    rdy_mode = 0;
    fault(16'h0008, 16'h0010, 32'h0000_8000, 32'h0000_0246, 32'h0040_1234, 32'h0000_0002,
          16'h0010, 32'hC000_9000, 16'h0008, 32'hC010_0000, 1'b0);
    fault(16'h001B, 16'h0023, 32'hBFFF_F000, 32'h0000_0202, 32'h0804_8ABC, 32'h0000_0007,
          16'h0010, 32'hC123_4000, 16'h0008, 32'hC010_0040, 1'b0);
    rdy_mode = 1;
    fault(16'h0019, 16'h0021, 32'h0000_1000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0006,
          16'h0018, 32'h0002_0000, 16'h0028, 32'hDEAD_BEE0, 1'b0);
    fault(16'h002A, 16'hFFF2, 32'h7FFF_FFF0, 32'hA5A5_5A5A, 32'h0000_0000, 32'h0000_0004,
          16'h0030, 32'h0000_0100, 16'h0038, 32'h0000_0400, 1'b1);
    fault(16'hFFFC, 16'h1234, 32'h0000_0010, 32'h0000_0000, 32'hFFFF_FFFC, 32'hFFFF_FFF8,
          16'h0040, 32'h0000_0200, 16'h0048, 32'h0000_0800, 1'b1);
    rdy_mode = 0;
    fault(16'h0000, 16'h0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0010, 32'h0000_0003,
          16'hFFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'hFFFF_FFFF, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule